// File: doc/BRIEF.md
# Watchdog Timer with Control Register

This block is a watchdog timer that software manages through one 8-bit control register on a plain write/read bus. After it is started, a free-running up-counter advances every clock. Software must keep it from reaching its terminal count by asking for a refresh. To ask, it sets a refresh bit, and hardware clears that bit itself once the counter has been reloaded. When the counter wraps from all ones to zero, a sticky status flag is set. If resets are enabled, a one-cycle chip reset request is also raised. A second enable lets that reset also drive a reset pin, held high for a fixed number of cycles.

The status flag tells software, after a restart, whether the previous reset came from the watchdog. A watchdog-caused reset clears the control bits and the counter but leaves the flag set. A power-on reset or an external reset clears everything, the flag included. The two reset inputs are kept separate so that the block can tell these causes apart from its own watchdog reset.

Control register layout (reads and writes): bit 0 start, bit 1 refresh request, bit 2 overflow flag, bit 3 reset enable, bit 4 pin output enable, bits 7..5 unused.

Top module: `wdog_ctl`

## Requirements
- R1: While por_n or ext_rst_n is low, and after either is released, rd_data is 0x00, chip_rst is 0 and rst_pin is 0.
- R2: Bits 7..5 of rd_data always read 0, whatever value is written to them.
- R3: The counter advances only while start (bit 0) is 1. With start at 0, no overflow occurs however long the block waits.
- R4: Writing 1 to the refresh bit (bit 1) reloads the counter to zero one cycle after the write. The next overflow then comes 2^CNT_W cycles after that reload, and not at the time it would have come without the refresh.
- R5: The flag (bit 2) becomes 1 in the cycle after the counter wraps from all ones to zero. Writing 1 to bit 2 clears it. Writing 0 to bit 2 leaves it unchanged.
- R6: When reset enable (bit 3) is 0, an overflow sets the flag but raises no chip_rst, and the counter keeps running.
- R7: When reset enable is 1, an overflow raises chip_rst for exactly one cycle. In that same cycle start, refresh, reset enable and output enable read back 0 and the flag reads 1.
- R8: When a watchdog reset occurs with output enable (bit 4) at 1, rst_pin is high for exactly PULSE_LEN (default 32) cycles. The pulse starts in the cycle of chip_rst and is not cut short by the internal reset. With output enable at 0, rst_pin stays low.
- R9: A low pulse on ext_rst_n or on por_n clears a set flag.
- R10: A refresh that coincides with the terminal count wins, and no flag and no chip_rst result. This holds both when the refresh write lands on the wrap edge and when the refresh bit is already pending during the terminal-count cycle.
- R11: The refresh bit reads 1 for exactly one cycle after a write of 1, then reads 0 without any further write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External hardware reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register contents |
| chip_rst | output | 1 | One-cycle watchdog reset request to the chip |
| rst_pin | output | 1 | Stretched watchdog reset for the reset pin |

## Verification
The hardest case to reach is a refresh that collides with the terminal count, because the counter value cannot be seen at the ports. The stimulus first reloads the stopped counter to a known zero with a refresh write. It then starts the counter and times every later write against a cycle count taken from that start. This puts a refresh write exactly on the wrap edge, and in a second case places a pending refresh bit over the terminal-count cycle. In both cases the absence of flag and chip reset is checked, and so is the delayed overflow after a refresh.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W   = 8;
  localparam int B_START = 0;
  localparam int B_REFR  = 1;
  localparam int B_FLAG  = 2;
  localparam int B_RSTEN = 3;
  localparam int B_OUTEN = 4;
  localparam int USED_W  = 5;

  typedef struct packed {
    logic out_en;
    logic rst_en;
    logic flag;
    logic refr;
    logic start;
  } wdog_ctl_t;

  function automatic logic [REG_W-1:0] ctl_to_bus(input wdog_ctl_t c);
    logic [REG_W-1:0] v;
    v          = '0;
    v[B_START] = c.start;
    v[B_REFR]  = c.refr;
    v[B_FLAG]  = c.flag;
    v[B_RSTEN] = c.rst_en;
    v[B_OUTEN] = c.out_en;
    return v;
  endfunction
endpackage

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic reload,
  input  logic clr,
  input  logic hold_off,
  output logic wrap
);
  localparam logic [CNT_W-1:0] TERM = '1;

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic at_term(input logic [CNT_W-1:0] v);
    return v == TERM;
  endfunction

  assign wrap = run && at_term(cnt) && !reload && !hold_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (reload) cnt <= '0;
    else if (run)    cnt <= step(cnt);
  end

  // R3: a stopped counter holds its value
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload && !clr) |=> $stable(cnt));

  // R4: a reload leaves the counter at zero
  a_r4_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == '0));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wrap,
  input  logic             wd_rst,
  output wdog_ctl_t        ctl
);
  logic unused_hi_bits;
  assign unused_hi_bits = ^wr_data[REG_W-1:USED_W];

  logic wr_start, wr_refr, wr_clr, wr_rsten, wr_outen;
  assign wr_start = wr_en & wr_data[B_START];
  assign wr_refr  = wr_en & wr_data[B_REFR];
  assign wr_clr   = wr_en & wr_data[B_FLAG];
  assign wr_rsten = wr_en & wr_data[B_RSTEN];
  assign wr_outen = wr_en & wr_data[B_OUTEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wd_rst) begin
      ctl        <= '0;
      ctl.flag   <= 1'b1;
    end else begin
      if (wr_en) begin
        ctl.start  <= wr_start;
        ctl.rst_en <= wr_rsten;
        ctl.out_en <= wr_outen;
      end
      ctl.refr <= wr_refr && !ctl.refr;
      if (wrap)        ctl.flag <= 1'b1;
      else if (wr_clr) ctl.flag <= 1'b0;
    end
  end

  // R11: refresh request lasts one cycle
  a_r11_refresh_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.refr |=> !ctl.refr);

  // R5: the flag only drops on a write of 1 to its bit
  a_r5_flag_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl.flag) |-> $past(wr_en && wr_data[B_FLAG]));
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic en,
  output logic pin
);
  localparam int PW = $clog2(LEN + 1);
  localparam logic [PW-1:0] LOAD = PW'(LEN);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left <= '0;
    else if (fire && en)     left <= LOAD;
    else if (left != '0)     left <= left - 1'b1;
  end

  assign pin = (left != '0);

  // R8: pin only rises from an enabled watchdog reset
  a_r8_pin_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin) |-> $past(fire && en));

  // R8: remaining length never exceeds the configured pulse
  a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    left <= LOAD);
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 32
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             chip_rst,
  output logic             rst_pin
);
  logic      hw_rst_n;
  logic      refr_wr;
  logic      wrap;
  logic      wd_rst;
  wdog_ctl_t ctl;

  assign hw_rst_n = por_n & ext_rst_n;
  assign refr_wr  = wr_en & wr_data[B_REFR];
  assign wd_rst   = wrap & ctl.rst_en;

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (hw_rst_n),
    .run      (ctl.start),
    .reload   (ctl.refr),
    .clr      (wd_rst),
    .hold_off (refr_wr),
    .wrap     (wrap)
  );

  wdog_regs u_regs (
    .clk     (clk),
    .rst_n   (hw_rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wrap    (wrap),
    .wd_rst  (wd_rst),
    .ctl     (ctl)
  );

  wdog_stretch #(.LEN(PULSE_LEN)) u_stretch (
    .clk   (clk),
    .rst_n (hw_rst_n),
    .fire  (wd_rst),
    .en    (ctl.out_en),
    .pin   (rst_pin)
  );

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) chip_rst <= 1'b0;
    else           chip_rst <= wd_rst;
  end

  assign rd_data = ctl_to_bus(ctl);

  // R7: chip reset request is a single cycle
  a_r7_one_shot: assert property (@(posedge clk) disable iff (!hw_rst_n)
    chip_rst |=> !chip_rst);

  // R7: control cleared, flag kept, during chip reset
  a_r7_state_on_reset: assert property (@(posedge clk) disable iff (!hw_rst_n)
    chip_rst |-> (ctl.flag && !ctl.start && !ctl.rst_en && !ctl.out_en));

  // R6: overflow without reset enable raises no chip reset
  a_r6_no_reset_when_off: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (wrap && !ctl.rst_en) |=> !chip_rst);

  // R10: a pending refresh blocks the overflow flag
  a_r10_refresh_wins: assert property (@(posedge clk) disable iff (!hw_rst_n)
    ctl.refr |=> !$rose(ctl.flag));

  // R2: unused upper bits read zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!hw_rst_n)
    rd_data[REG_W-1:USED_W] == '0);
endmodule

// File: tb/wdog_ctl_bench.sv
module wdog_ctl_bench;
  localparam int W  = 5;
  localparam int PL = 32;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       chip_rst;
  logic       rst_pin;

  wdog_ctl #(.CNT_W(W), .PULSE_LEN(PL)) u_wdog_ctl (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .chip_rst(chip_rst), .rst_pin(rst_pin)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         at;
    int         sig;
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  function automatic logic [7:0] probe(input int sig);
    if (sig == 0)      return rd_data;
    else if (sig == 1) return {7'd0, chip_rst};
    else               return {7'd0, rst_pin};
  endfunction

  function automatic string sname(input int sig);
    if (sig == 0)      return "rd_data";
    else if (sig == 1) return "chip_rst";
    else               return "rst_pin";
  endfunction

  task automatic compare(input int sig, input logic [7:0] exp_v, input string req);
    logic [7:0] act;
    act = probe(sig);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s cycle %0d %s actual=%h expected=%h", req, cyc, sname(sig), act, exp_v);
    end
  endtask

  // monitor: pops expected items when their cycle arrives
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        compare(q[i].sig, q[i].val, q[i].req);
        q.delete(i);
      end
    end
  end

  task automatic expect_at(input int at, input int sig, input logic [7:0] v, input string req);
    exp_t e;
    e.at = at; e.sig = sig; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic finish_run();
    foreach (q[i]) begin
      n_cmp++;
      n_bad++;
      $display("FAIL %s item for cycle %0d never compared actual=none expected=%h", q[i].req, q[i].at, q[i].val);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog cycle %0d actual=running expected=finished", cyc);
      finish_run();
    end
  end

  initial begin
    int e, r, s, a, b, c, p;
    repeat (3) @(negedge clk);
    compare(0, 8'h00, "R1");
    por_n = 1'b1;
    @(negedge clk);
    compare(0, 8'h00, "R1");
    compare(1, 8'h00, "R1");
    compare(2, 8'h00, "R1");

    wr(8'hE0);
    compare(0, 8'h00, "R2");

    // R3 and R5: overflow timing from a zero counter
    wr(8'h01); e = cyc;
    expect_at(e + 31, 0, 8'h01, "R3");
    expect_at(e + 32, 0, 8'h05, "R5");
    expect_at(e + 32, 1, 8'h00, "R6");
    expect_at(e + 33, 0, 8'h05, "R6");
    wait_to(e + 34);
    wr(8'h01);
    compare(0, 8'h05, "R5");
    wr(8'h04);
    compare(0, 8'h00, "R5");
    e = cyc;
    wait_to(e + 70);
    compare(0, 8'h00, "R3");

    // R11: refresh while stopped, also zeroes the counter
    wr(8'h02);
    compare(0, 8'h02, "R11");
    @(negedge clk);
    compare(0, 8'h00, "R11");

    // R4: refresh postpones the overflow
    wr(8'h01); s = cyc;
    wait_to(s + 20);
    wr(8'h03); r = cyc;
    compare(0, 8'h03, "R11");
    expect_at(r + 1, 0, 8'h01, "R11");
    expect_at(r + 11, 0, 8'h01, "R4");
    expect_at(r + 32, 0, 8'h01, "R4");
    expect_at(r + 33, 0, 8'h05, "R4");
    wait_to(r + 35);
    wr(8'h04);
    wr(8'h02);
    @(negedge clk);
    compare(0, 8'h00, "R4");

    // R7 and R8: reset with pin output
    wr(8'h19); a = cyc;
    expect_at(a + 31, 0, 8'h19, "R7");
    expect_at(a + 31, 1, 8'h00, "R7");
    expect_at(a + 31, 2, 8'h00, "R8");
    expect_at(a + 32, 0, 8'h04, "R7");
    expect_at(a + 32, 1, 8'h01, "R7");
    expect_at(a + 32, 2, 8'h01, "R8");
    expect_at(a + 33, 1, 8'h00, "R7");
    expect_at(a + 63, 2, 8'h01, "R8");
    expect_at(a + 64, 2, 8'h00, "R8");
    wait_to(a + 70);
    compare(0, 8'h04, "R7");

    // R8: reset with pin output disabled
    wr(8'h04);
    wr(8'h09); b = cyc;
    expect_at(b + 32, 1, 8'h01, "R7");
    expect_at(b + 32, 0, 8'h04, "R7");
    expect_at(b + 32, 2, 8'h00, "R8");
    expect_at(b + 40, 2, 8'h00, "R8");
    wait_to(b + 42);

    // R9: external reset clears the flag
    compare(0, 8'h04, "R9");
    ext_rst_n = 1'b0;
    @(negedge clk);
    ext_rst_n = 1'b1;
    @(negedge clk);
    compare(0, 8'h00, "R9");

    // R9: power-on reset clears the flag
    wr(8'h01); p = cyc;
    wait_to(p + 33);
    compare(0, 8'h05, "R5");
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    compare(0, 8'h00, "R9");
    compare(2, 8'h00, "R1");

    // R10: refresh write lands on the wrap edge
    wr(8'h09); c = cyc;
    wait_to(c + 31);
    wr(8'h0B);
    compare(0, 8'h0B, "R10");
    compare(1, 8'h00, "R10");
    @(negedge clk);
    compare(0, 8'h09, "R10");
    // R10: refresh pending during the terminal-count cycle
    wait_to(c + 63);
    wr(8'h0B);
    compare(0, 8'h0B, "R10");
    @(negedge clk);
    compare(0, 8'h09, "R10");
    compare(1, 8'h00, "R10");
    wr(8'h00);
    compare(0, 8'h00, "R10");
    compare(2, 8'h00, "R10");

    repeat (4) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule